// File: doc/BRIEF.md
# Butterfly Multistage Switching Network

This block is an N-port butterfly network made of two-by-two switching elements arranged in log2(N) ranks. Every input port may inject one packet per cycle. A packet carries a destination port, a broadcast bit and a data word. The network fills in the source address from the injecting port. Each element reads one bit of the routing word, which is the XOR of the source and destination addresses. Rank s pairs the lines whose indices differ only in bit s and consults bit s of the routing word. A clear bit keeps the packet on its own line. A set bit moves it to the partner line. Because of this, a packet reaches its destination port along exactly one path.

An element can take one of four settings: pass-through, swap, copy-upper-to-both and copy-lower-to-both. A packet with its broadcast bit set is copied onto both element outputs at every rank, so it reaches every output port. If two packets need the same element output in the same cycle, the upper input keeps it. The lower packet is discarded, and a blocked flag is raised for its source port in that cycle. Each rank ends in one register, so the network has a fixed latency of log2(N) cycles.

Top module: `bfly_net`

## Requirements
- R1: While reset is asserted and after it is released with no traffic, every `out_vld` bit and every `blocked` bit is 0.
- R2: A packet that is not dropped and is injected in cycle t appears in cycle t+log2(N) at output port `dst`, with its data unchanged.
- R3: At rank s, a non-broadcast packet keeps its line when bit s of (src XOR dst) is 0. It moves to the line whose index differs in bit s when that bit is 1. With no competing traffic, no blocked flag is raised.
- R4: When two non-broadcast packets at one element need the same output, the upper packet (index bit s = 0) is kept and the lower packet is dropped. `blocked[src of dropped]` is 1 during cycle t+s, where t is the injection cycle and s is the rank.
- R5: A broadcast packet is copied onto both outputs of every element it passes. Injected alone, it appears on all N output ports log2(N) cycles later.
- R6: An upper-input broadcast claims both outputs of its element, and any lower-input packet at that element is dropped and flagged.
- R7: A lower-input broadcast uses copy-lower-to-both only when the upper input is idle. If the upper input holds a packet, the upper packet is routed normally and the broadcast is dropped and flagged.
- R8: A batch whose destinations are dst = src XOR c, for a common constant c, is delivered in full with no blocked flag.
- R9: `out_src` on each valid output port gives the port that injected the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_vld | input | N | Packet present on each input port |
| in_bc | input | N | Broadcast bit per input port |
| in_dst | input | N*log2(N) | Destination port per input, port i in bits [i*AW +: AW] |
| in_dat | input | N*DW | Data word per input, port i in bits [i*DW +: DW] |
| out_vld | output | N | Packet present on each output port |
| out_src | output | N*log2(N) | Source port of the packet on each output |
| out_dat | output | N*DW | Data word on each output |
| blocked | output | N | Per source port, a packet of that source was dropped this cycle |

## Verification
Several things can happen in the same cycle: packets are injected and routed at rank 0, packets from earlier batches are routed at later ranks, and blocked flags from both appear together. Conflicts are provoked at rank 0 and, through lines that first meet at rank 1, at a later rank. Broadcasts are provoked on both upper and lower inputs, with and without a packet at the partner input. Every batch is judged against a bench-side rank-by-rank routing model that checks the blocked vector per cycle and the outputs after three cycles. Hand-computed expectations back up the model for the named corner cases.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  typedef enum logic [1:0] {
    SET_STRAIGHT = 2'd0,
    SET_EXCHANGE = 2'd1,
    SET_UP_BCAST = 2'd2,
    SET_LO_BCAST = 2'd3
  } elem_set_e;

  // Index of the upper line of element e in rank s (bit s of the line index is 0).
  function automatic int lo_line(input int e, input int s);
    return ((e >> s) << (s + 1)) | (e & ((1 << s) - 1));
  endfunction

endpackage

// File: rtl/bfly_elem.sv
module bfly_elem
  import bfly_pkg::*;
#(
  parameter int AW  = 3,
  parameter int DW  = 8,
  parameter int STG = 0,
  localparam int PW = DW + 2*AW + 2
) (
  input  logic [PW-1:0] up_i,
  input  logic [PW-1:0] dn_i,
  output logic [PW-1:0] up_o,
  output logic [PW-1:0] dn_o,
  output logic          dn_drop
);
  // packet layout: {vld, bc, src, dst, dat}
  localparam int VB = PW - 1;
  localparam int BB = PW - 2;
  localparam int SL = DW + AW;
  localparam int DL = DW;

  logic uv, ub, ux, lv, lb, lx;
  elem_set_e sel;
  logic [PW-1:0] dn_eff;

  assign uv = up_i[VB];
  assign ub = up_i[BB];
  assign ux = up_i[SL+STG] ^ up_i[DL+STG];
  assign lv = dn_i[VB];
  assign lb = dn_i[BB];
  assign lx = dn_i[SL+STG] ^ dn_i[DL+STG];

  // setting decision
  always_comb begin
    sel     = SET_STRAIGHT;
    dn_drop = 1'b0;
    if (uv && ub) begin
      sel     = SET_UP_BCAST;
      dn_drop = lv;
    end else if (lv && lb) begin
      if (uv) begin
        dn_drop = 1'b1;
        sel     = ux ? SET_EXCHANGE : SET_STRAIGHT;
      end else begin
        sel = SET_LO_BCAST;
      end
    end else if (uv) begin
      sel     = ux ? SET_EXCHANGE : SET_STRAIGHT;
      dn_drop = lv && (ux != lx);
    end else begin
      sel = lx ? SET_EXCHANGE : SET_STRAIGHT;
    end
  end

  // output steering
  always_comb begin
    dn_eff = dn_drop ? '0 : dn_i;
    unique case (sel)
      SET_STRAIGHT: begin up_o = up_i;   dn_o = dn_eff; end
      SET_EXCHANGE: begin up_o = dn_eff; dn_o = up_i;   end
      SET_UP_BCAST: begin up_o = up_i;   dn_o = up_i;   end
      default:      begin up_o = dn_i;   dn_o = dn_i;   end
    endcase
  end

endmodule

// File: rtl/bfly_stage.sv
module bfly_stage #(
  parameter int N   = 8,
  parameter int AW  = 3,
  parameter int DW  = 8,
  parameter int STG = 0,
  localparam int PW = DW + 2*AW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N*PW-1:0] d_i,
  output logic [N*PW-1:0] q_o,
  output logic [N-1:0]    drop_o
);
  logic [N*PW-1:0] nxt;
  logic [N-1:0]    vld_q;
  logic [PW-2:0]   pay_q [N];

  for (genvar e = 0; e < N/2; e++) begin : g_elem
    localparam int LO = bfly_pkg::lo_line(e, STG);
    localparam int HI = LO + (1 << STG);
    bfly_elem #(.AW(AW), .DW(DW), .STG(STG)) u_elem (
      .up_i    (d_i[LO*PW +: PW]),
      .dn_i    (d_i[HI*PW +: PW]),
      .up_o    (nxt[LO*PW +: PW]),
      .dn_o    (nxt[HI*PW +: PW]),
      .dn_drop (drop_o[HI])
    );
    assign drop_o[LO] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      for (int j = 0; j < N; j++) vld_q[j] <= nxt[j*PW + PW - 1];
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < N; j++) begin
      if (nxt[j*PW + PW - 1]) pay_q[j] <= nxt[j*PW +: PW-1];
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_out
    assign q_o[j*PW +: PW] = {vld_q[j], pay_q[j]};
  end

endmodule

// File: rtl/bfly_net.sv
module bfly_net #(
  parameter int N  = 8,
  parameter int DW = 8,
  localparam int LG = $clog2(N),
  localparam int AW = LG,
  localparam int PW = DW + 2*AW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    in_vld,
  input  logic [N-1:0]    in_bc,
  input  logic [N*AW-1:0] in_dst,
  input  logic [N*DW-1:0] in_dat,
  output logic [N-1:0]    out_vld,
  output logic [N*AW-1:0] out_src,
  output logic [N*DW-1:0] out_dat,
  output logic [N-1:0]    blocked
);
  logic [N*PW-1:0] stg_d [LG+1];
  logic [N-1:0]    drop  [LG];

  for (genvar i = 0; i < N; i++) begin : g_inj
    localparam logic [AW-1:0] SRC = AW'(i);
    assign stg_d[0][i*PW +: PW] =
      {in_vld[i], in_bc[i], SRC, in_dst[i*AW +: AW], in_dat[i*DW +: DW]};
  end

  for (genvar s = 0; s < LG; s++) begin : g_rank
    bfly_stage #(.N(N), .AW(AW), .DW(DW), .STG(s)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (stg_d[s]),
      .q_o    (stg_d[s+1]),
      .drop_o (drop[s])
    );
  end

  always_comb begin
    blocked = '0;
    for (int s = 0; s < LG; s++) begin
      for (int j = 0; j < N; j++) begin
        if (drop[s][j]) blocked[stg_d[s][j*PW + DW + AW +: AW]] = 1'b1;
      end
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_eject
    assign out_vld[j]          = stg_d[LG][j*PW + PW - 1];
    assign out_src[j*AW +: AW] = stg_d[LG][j*PW + DW + AW +: AW];
    assign out_dat[j*DW +: DW] = stg_d[LG][j*PW +: DW];
  end

endmodule

module bfly_net_chk #(
  parameter int N  = 8,
  parameter int DW = 8,
  localparam int LG = $clog2(N),
  localparam int AW = LG
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    in_vld,
  input logic [N-1:0]    in_bc,
  input logic [N*AW-1:0] in_dst,
  input logic [N-1:0]    out_vld,
  input logic [N*AW-1:0] out_src,
  input logic [N-1:0]    blocked
);
  logic [N-1:0]    hv [LG];
  logic [N-1:0]    hb [LG];
  logic [N*AW-1:0] hd [LG];

  always_ff @(posedge clk) begin
    hv[0] <= in_vld;
    hb[0] <= in_bc;
    hd[0] <= in_dst;
    for (int k = 1; k < LG; k++) begin
      hv[k] <= hv[k-1];
      hb[k] <= hb[k-1];
      hd[k] <= hd[k-1];
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_port
    // R2 / R9: a packet on port j was injected log2(N) cycles before by out_src
    p_arrive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[j] |-> hv[LG-1][out_src[j*AW +: AW]]);
    // R3: a non-broadcast packet leaves at its own destination
    p_dest_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld[j] && !hb[LG-1][out_src[j*AW +: AW]])
        |-> (hd[LG-1][out_src[j*AW +: AW]*AW +: AW] == AW'(j)));
  end

  for (genvar j = 0; j < N; j += 2) begin : g_pair
    p_upper_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld[j] && in_vld[j+1] && !in_bc[j] && !in_bc[j+1]
        && (in_dst[j*AW] == in_dst[(j+1)*AW])) |-> blocked[j+1]);
    p_lo_bcast_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld[j] && in_vld[j+1] && in_bc[j+1]) |-> blocked[j+1]);
  end

  p_up_bcast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld[0] && in_bc[0] && in_vld[1]) |-> blocked[1]);

  p_bcast_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld[0] && in_bc[0]) |-> ##LG (&out_vld));

endmodule

bind bfly_net bfly_net_chk #(.N(N), .DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_vld  (in_vld),
  .in_bc   (in_bc),
  .in_dst  (in_dst),
  .out_vld (out_vld),
  .out_src (out_src),
  .blocked (blocked)
);

// File: tb/bfly_net_test.sv
`timescale 1ns/1ps
module bfly_net_test;
  localparam int N  = 8;
  localparam int DW = 8;
  localparam int LG = 3;
  localparam int AW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    in_vld = '0;
  logic [N-1:0]    in_bc = '0;
  logic [N*AW-1:0] in_dst = '0;
  logic [N*DW-1:0] in_dat = '0;
  logic [N-1:0]    out_vld;
  logic [N*AW-1:0] out_src;
  logic [N*DW-1:0] out_dat;
  logic [N-1:0]    blocked;

  bfly_net #(.N(N), .DW(DW)) uut (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0, batch = 0;
  bit finished = 0;

  // stimulus for one batch
  bit tv[N], tb[N];
  int td[N];
  // bench routing model
  bit mv[LG+1][N], mb[LG+1][N];
  int ms[LG+1][N], md[LG+1][N];
  bit mk[LG][N];
  // captured results
  logic [N-1:0] cap_vld;
  logic [N-1:0] cap_blk [LG];
  int cap_src[N];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h batch=%0d", tag, act, exp, batch);
    end
  endtask

  task automatic clear_batch();
    for (int i = 0; i < N; i++) begin tv[i] = 0; tb[i] = 0; td[i] = 0; end
  endtask

  task automatic mcopy(int s, int to, int from);
    mv[s+1][to] = mv[s][from]; mb[s+1][to] = mb[s][from];
    ms[s+1][to] = ms[s][from]; md[s+1][to] = md[s][from];
  endtask

  task automatic model();
    for (int i = 0; i < N; i++) begin
      mv[0][i] = tv[i]; mb[0][i] = tb[i]; ms[0][i] = i; md[0][i] = td[i];
    end
    for (int s = 0; s < LG; s++) begin
      for (int i = 0; i < N; i++) begin mv[s+1][i] = 0; mk[s][i] = 0; end
      for (int u = 0; u < N; u++) begin
        if (((u >> s) & 1) == 0) begin
          int l = u | (1 << s);
          bit ux = ((ms[s][u] ^ md[s][u]) >> s) & 1;
          bit lx = ((ms[s][l] ^ md[s][l]) >> s) & 1;
          int ut = ux ? l : u;
          int lt = lx ? u : l;
          if (mv[s][u] && mb[s][u]) begin
            mcopy(s, u, u); mcopy(s, l, u);
            if (mv[s][l]) mk[s][ms[s][l]] = 1;
          end else if (mv[s][l] && mb[s][l] && !mv[s][u]) begin
            mcopy(s, u, l); mcopy(s, l, l);
          end else begin
            if (mv[s][u]) mcopy(s, ut, u);
            if (mv[s][l]) begin
              if (mv[s][u] && (mb[s][l] || ut == lt)) mk[s][ms[s][l]] = 1;
              else mcopy(s, lt, l);
            end
          end
        end
      end
    end
  endtask

  // inject one batch, check the blocked vector in each rank's cycle and the outputs
  task automatic send();
    logic [N-1:0] eb;
    logic [N-1:0] ev;
    model();
    @(negedge clk);
    batch++;
    for (int i = 0; i < N; i++) begin
      in_vld[i] = tv[i];
      in_bc[i]  = tb[i];
      in_dst[i*AW +: AW] = AW'(td[i]);
      in_dat[i*DW +: DW] = {3'(i), 5'(batch)};
    end
    for (int k = 0; k < LG; k++) begin
      #1;
      cap_blk[k] = blocked;
      for (int i = 0; i < N; i++) eb[i] = mk[k][i];
      chk("R4 blocked per rank (model)", 32'(blocked), 32'(eb));
      @(negedge clk);
      if (k == 0) begin in_vld = '0; in_bc = '0; end
    end
    #1;
    cap_vld = out_vld;
    for (int i = 0; i < N; i++) ev[i] = mv[LG][i];
    chk("R2 out_vld (model)", 32'(out_vld), 32'(ev));
    for (int p = 0; p < N; p++) begin
      cap_src[p] = int'(out_src[p*AW +: AW]);
      if (mv[LG][p]) begin
        chk("R9 out_src (model)", 32'(out_src[p*AW +: AW]), 32'(ms[LG][p]));
        chk("R2 out_dat (model)", 32'(out_dat[p*DW +: DW]),
            32'({3'(ms[LG][p]), 5'(batch)}));
      end
    end
  endtask

  function automatic logic [N-1:0] blk_any();
    return cap_blk[0] | cap_blk[1] | cap_blk[2];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_vld in reset", 32'(out_vld), 0);
    chk("R1 blocked in reset", 32'(blocked), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 out_vld after reset", 32'(out_vld), 0);
    chk("R1 blocked after reset", 32'(blocked), 0);

    // R2 R3 R9: every single source to every destination
    for (int s = 0; s < N; s++) begin
      for (int d = 0; d < N; d++) begin
        clear_batch(); tv[s] = 1; td[s] = d;
        send();
        chk("R2 lone packet port", 32'(cap_vld), 32'(1 << d));
        chk("R9 lone packet source", 32'(cap_src[d]), 32'(s));
        chk("R3 lone packet not blocked", 32'(blk_any()), 0);
      end
    end

    // R8: uniform xor shift permutations
    for (int c = 0; c < N; c++) begin
      clear_batch();
      for (int i = 0; i < N; i++) begin tv[i] = 1; td[i] = i ^ c; end
      send();
      chk("R8 all delivered", 32'(cap_vld), 32'hFF);
      chk("R8 no blocked", 32'(blk_any()), 0);
      for (int i = 0; i < N; i++) chk("R8 source at i^c", 32'(cap_src[i ^ c]), 32'(i));
    end

    // R4: affine permutations (some conflict at later ranks), judged by the model
    for (int a = 1; a < N; a += 2) begin
      for (int b = 0; b < N; b++) begin
        clear_batch();
        for (int i = 0; i < N; i++) begin tv[i] = 1; td[i] = (a * i + b) % N; end
        send();
      end
    end

    // R4 rank 0 conflict: inputs 0 and 1 both to port 0
    clear_batch(); tv[0] = 1; tv[1] = 1;
    send();
    chk("R4 rank0 blocked", 32'(cap_blk[0]), 32'h02);
    chk("R4 rank0 winner port", 32'(cap_vld), 32'h01);
    chk("R4 rank0 winner source", 32'(cap_src[0]), 0);

    // R4 rank 1 conflict: inputs 0 and 2 both to port 0
    clear_batch(); tv[0] = 1; tv[2] = 1;
    send();
    chk("R4 rank1 quiet in cycle 0", 32'(cap_blk[0]), 0);
    chk("R4 rank1 blocked", 32'(cap_blk[1]), 32'h04);
    chk("R4 rank1 winner port", 32'(cap_vld), 32'h01);

    // R5: lone broadcast from every source (odd ones use lower broadcast)
    for (int s = 0; s < N; s++) begin
      clear_batch(); tv[s] = 1; tb[s] = 1; td[s] = s;
      send();
      chk("R5 broadcast reaches all", 32'(cap_vld), 32'hFF);
      chk("R5 broadcast not blocked", 32'(blk_any()), 0);
      for (int p = 0; p < N; p++) chk("R5 broadcast source", 32'(cap_src[p]), 32'(s));
    end

    // R6: upper broadcast beats a lower packet
    clear_batch(); tv[0] = 1; tb[0] = 1; tv[1] = 1; td[1] = 5;
    send();
    chk("R6 lower dropped", 32'(cap_blk[0]), 32'h02);
    chk("R6 broadcast reaches all", 32'(cap_vld), 32'hFF);
    chk("R6 port5 source", 32'(cap_src[5]), 0);

    // R7: lower broadcast loses to an upper packet
    clear_batch(); tv[0] = 1; td[0] = 3; tv[1] = 1; tb[1] = 1;
    send();
    chk("R7 lower broadcast dropped", 32'(cap_blk[0]), 32'h02);
    chk("R7 upper delivered", 32'(cap_vld), 32'h08);
    chk("R7 upper source", 32'(cap_src[3]), 0);

    // mixed broadcast and unicast traffic, judged by the model
    for (int b = 0; b < N; b++) begin
      clear_batch();
      for (int i = 0; i < N; i++) begin tv[i] = 1; td[i] = (3 * i + b) % N; end
      tb[b] = 1;
      send();
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule